// File: doc/BRIEF.md
# Audio Bit Clock Prescaler

This block derives the audio clocks of a serial audio port from a fast kernel clock. Everything runs in the kernel clock domain. Each derived clock comes out twice: as a registered square-wave level, and, for the bit clock, as a one-cycle enable strobe. The serializer uses the strobe in place of a second clock. The divide ratio is set by an 8-bit field and an extra odd bit. The ratio is twice the field plus the odd bit. A field of zero bypasses the divider. Some field values are forbidden, and the block flags them instead of producing a clock.

There are two ways to reach the bit clock. With the master clock enabled, the block is in master mode and the prescaler output is the master clock. This clock runs at 256 times the frame rate for two-channel standards and at 128 times the frame rate in PCM mode. A second stage then divides it down to the bit clock. The second-stage factor follows from the frame length. The frame is 32 bits in the two-channel standards and 16 bits in PCM, and both double when 32-bit slots are selected. Without the master clock, the prescaler output is the bit clock itself.

A new setting is held back until the current output period ends, so a change never produces a short pulse.

Top module: `audclk_prescaler`

## Requirements
- R1: In direct mode (master clock not in use), with a legal setting, the bit clock strobe `bclk_tick_o` repeats every R kernel cycles. For a nonzero field, R = 2*`cfg_div` + `cfg_odd`.
- R2: When `cfg_div` = 0 the divider is bypassed and R = 1, whatever `cfg_odd` is. In direct mode the strobe is then high on every cycle and `bclk_o` stays high.
- R3: In direct mode `bclk_o` is high for ceil(R/2) cycles of each period and low for the rest. Even ratios therefore give an equal duty cycle, and odd ratios a high phase one cycle longer than the low phase.
- R4: `bclk_tick_o` is high exactly in the first high cycle of each bit clock period. Every rising edge of `bclk_o` comes with the strobe.
- R5: A setting is illegal when `cfg_div` = 1 with `cfg_odd` = 1, or when `cfg_div` is above 127. Once such a setting is taken, `cfg_err_o` is 1 and `bclk_o`, `mclk_o` and `bclk_tick_o` stay 0.
- R6: While the error is set, a legal setting is taken on the next clock edge. The error then clears and the clocks restart with a full high phase.
- R7: When `cfg_mclk_en` = 1 and `cfg_master` = 1, `mclk_o` has period R and high time ceil(R/2). The bit clock period is 8 master clock periods when `cfg_wide` = 0 and 4 when `cfg_wide` = 1, in both the two-channel standards and PCM mode (`cfg_pcm` = 1). `bclk_o` is high for the first half of those periods.
- R8: `mclk_o` stays 0 unless both `cfg_mclk_en` and `cfg_master` are 1. Otherwise the bit clock is taken directly from the prescaler, as in R1.
- R9: A setting change made in the middle of a period leaves the running period at its old length. The new ratio applies from the next period boundary.
- R10: During reset `bclk_o`, `mclk_o`, `bclk_tick_o` and `cfg_err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | 8 | Linear divide field |
| cfg_odd | input | 1 | Adds one to the doubled field |
| cfg_mclk_en | input | 1 | Master clock output enable |
| cfg_master | input | 1 | Clock master mode |
| cfg_pcm | input | 1 | PCM standard selected (128x master clock, 16-bit frame) |
| cfg_wide | input | 1 | 32-bit slots (frame length doubled) |
| mclk_o | output | 1 | Master clock level |
| bclk_o | output | 1 | Bit clock level |
| bclk_tick_o | output | 1 | One-cycle strobe at each bit clock rising edge |
| cfg_err_o | output | 1 | Illegal divider setting active |

## Verification
The bench builds the block with its default parameters: an 8-bit field with 127 as the largest legal value, master clock ratios of 256 and 128, and frame lengths of 32 and 16 bits. These values bring the largest legal ratio of 255 within reach, together with both forbidden codes (field 128, and field 1 with the odd bit). Both second-stage factors, 8 and 4, are also reachable. Periods and high times are measured at the ports, over a settled period that follows every setting change.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

    // Width of the linear divide field and of the period counter.
    localparam int AC_DIV_W = 8;
    localparam int AC_CNT_W = AC_DIV_W + 1;

    // One complete divider setting, shadowed as a unit.
    typedef struct packed {
        logic [AC_DIV_W-1:0] div;
        logic                odd;
        logic                mclk_en;
        logic                master;
        logic                pcm;
        logic                wide;
    } ac_cfg_t;

    // Kernel cycles per output period; a zero field bypasses the divider.
    function automatic logic [AC_CNT_W-1:0] ac_ratio(input ac_cfg_t c);
        if (c.div == '0)
            return AC_CNT_W'(1);
        return {c.div, c.odd};
    endfunction

    // Cycles spent high per period: the longer half for odd ratios.
    function automatic logic [AC_CNT_W-1:0] ac_high_len(input logic [AC_CNT_W-1:0] r);
        return (r + AC_CNT_W'(1)) >> 1;
    endfunction

    // Master clock periods per bit clock period.
    function automatic int ac_mclk_per_bclk(input logic pcm, input logic wide,
                                            input int fs_std, input int fs_pcm,
                                            input int fr_std, input int fr_pcm);
        int ratio;
        int frame;
        ratio = pcm ? fs_pcm : fs_std;
        frame = pcm ? fr_pcm : fr_std;
        if (wide)
            frame = frame * 2;
        return ratio / frame;
    endfunction

endpackage

// File: rtl/audclk_cfg_check.sv
module audclk_cfg_check
    import audclk_pkg::*;
#(
    parameter int DIV_MAX = 127
) (
    input  ac_cfg_t cfg,
    output logic    bad
);
    localparam logic [AC_DIV_W-1:0] LIM = AC_DIV_W'(DIV_MAX);

    logic odd_one;
    logic too_big;

    always_comb begin
        odd_one = (cfg.div == AC_DIV_W'(1)) && cfg.odd;
        too_big = (cfg.div > LIM);
        bad     = odd_one || too_big;
    end

    // Remaining fields take part in no legality rule.
    logic unused_ok;
    assign unused_ok = ^{cfg.mclk_en, cfg.master, cfg.pcm, cfg.wide};
endmodule

// File: rtl/audclk_divcore.sv
module audclk_divcore
    import audclk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ac_cfg_t cfg_in,
    input  logic    cfg_bad,
    output logic    use_mclk_o,
    output logic    pcm_o,
    output logic    wide_o,
    output logic    lvl_o,
    output logic    tick_o,
    output logic    err_o
);
    ac_cfg_t             act_q;
    logic [AC_CNT_W-1:0] cnt_q;
    logic                restart_q;
    logic [AC_CNT_W-1:0] ratio_act;
    logic [AC_CNT_W-1:0] hi_act;
    logic [AC_CNT_W-1:0] cnt_inc;
    logic                boundary;

    always_comb begin
        ratio_act = ac_ratio(act_q);
        hi_act    = ac_high_len(ratio_act);
        cnt_inc   = cnt_q + AC_CNT_W'(1);
        // A restart forces a period start; otherwise wait for the last cycle.
        boundary  = restart_q || (cnt_inc == ratio_act);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q     <= '0;
            cnt_q     <= '0;
            restart_q <= 1'b1;
            lvl_o     <= 1'b0;
            tick_o    <= 1'b0;
            err_o     <= 1'b0;
        end else if (boundary) begin
            act_q <= cfg_in;
            cnt_q <= '0;
            if (cfg_bad) begin
                restart_q <= 1'b1;
                lvl_o     <= 1'b0;
                tick_o    <= 1'b0;
                err_o     <= 1'b1;
            end else begin
                restart_q <= 1'b0;
                lvl_o     <= 1'b1;
                tick_o    <= 1'b1;
                err_o     <= 1'b0;
            end
        end else begin
            cnt_q  <= cnt_inc;
            lvl_o  <= (cnt_inc < hi_act);
            tick_o <= 1'b0;
        end
    end

    assign use_mclk_o = act_q.mclk_en & act_q.master;
    assign pcm_o      = act_q.pcm;
    assign wide_o     = act_q.wide;
endmodule

// File: rtl/audclk_bclk_stage.sv
module audclk_bclk_stage
    import audclk_pkg::*;
#(
    parameter int FS_STD    = 256,
    parameter int FS_PCM    = 128,
    parameter int FRAME_STD = 32,
    parameter int FRAME_PCM = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic use_mclk,
    input  logic pcm,
    input  logic wide,
    input  logic core_lvl,
    input  logic core_tick,
    input  logic core_err,
    output logic bclk_o,
    output logic tick_o
);
    localparam int N_STD = FS_STD / FRAME_STD;
    localparam int N_PCM = FS_PCM / FRAME_PCM;
    localparam int N_MAX = (N_STD > N_PCM) ? N_STD : N_PCM;
    localparam int SC_W  = $clog2(N_MAX) + 1;

    logic [SC_W-1:0] n_per;
    logic [SC_W-1:0] sc_q;
    logic [SC_W-1:0] sc_nxt;

    always_comb begin
        n_per  = SC_W'(ac_mclk_per_bclk(pcm, wide, FS_STD, FS_PCM, FRAME_STD, FRAME_PCM));
        sc_nxt = (sc_q >= n_per - SC_W'(1)) ? '0 : sc_q + SC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || core_err) begin
            sc_q   <= '1;
            bclk_o <= 1'b0;
            tick_o <= 1'b0;
        end else if (!use_mclk) begin
            // Direct path: one register stage behind the prescaler.
            sc_q   <= '1;
            bclk_o <= core_lvl;
            tick_o <= core_tick;
        end else if (core_tick) begin
            sc_q   <= sc_nxt;
            bclk_o <= (sc_nxt < (n_per >> 1));
            tick_o <= (sc_nxt == '0);
        end else begin
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/audclk_prescaler.sv
module audclk_prescaler
    import audclk_pkg::*;
#(
    parameter int DIV_MAX   = 127,
    parameter int FS_STD    = 256,
    parameter int FS_PCM    = 128,
    parameter int FRAME_STD = 32,
    parameter int FRAME_PCM = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [AC_DIV_W-1:0] cfg_div,
    input  logic                cfg_odd,
    input  logic                cfg_mclk_en,
    input  logic                cfg_master,
    input  logic                cfg_pcm,
    input  logic                cfg_wide,
    output logic                mclk_o,
    output logic                bclk_o,
    output logic                bclk_tick_o,
    output logic                cfg_err_o
);
    ac_cfg_t cfg_in;
    logic    cfg_bad;
    logic    use_mclk;
    logic    act_pcm;
    logic    act_wide;
    logic    core_lvl;
    logic    core_tick;
    logic    core_err;

    always_comb begin
        cfg_in.div     = cfg_div;
        cfg_in.odd     = cfg_odd;
        cfg_in.mclk_en = cfg_mclk_en;
        cfg_in.master  = cfg_master;
        cfg_in.pcm     = cfg_pcm;
        cfg_in.wide    = cfg_wide;
    end

    audclk_cfg_check #(.DIV_MAX(DIV_MAX)) u_check (
        .cfg (cfg_in),
        .bad (cfg_bad)
    );

    audclk_divcore u_core (
        .clk        (clk),
        .rst        (rst),
        .cfg_in     (cfg_in),
        .cfg_bad    (cfg_bad),
        .use_mclk_o (use_mclk),
        .pcm_o      (act_pcm),
        .wide_o     (act_wide),
        .lvl_o      (core_lvl),
        .tick_o     (core_tick),
        .err_o      (core_err)
    );

    audclk_bclk_stage #(
        .FS_STD    (FS_STD),
        .FS_PCM    (FS_PCM),
        .FRAME_STD (FRAME_STD),
        .FRAME_PCM (FRAME_PCM)
    ) u_bclk (
        .clk       (clk),
        .rst       (rst),
        .use_mclk  (use_mclk),
        .pcm       (act_pcm),
        .wide      (act_wide),
        .core_lvl  (core_lvl),
        .core_tick (core_tick),
        .core_err  (core_err),
        .bclk_o    (bclk_o),
        .tick_o    (bclk_tick_o)
    );

    assign mclk_o    = core_lvl & use_mclk;
    assign cfg_err_o = core_err;
endmodule

// File: rtl/audclk_prescaler_chk.sv
module audclk_prescaler_chk
    import audclk_pkg::*;
#(
    parameter int DIV_MAX = 127
) (
    input logic                clk,
    input logic                rst,
    input logic [AC_DIV_W-1:0] cfg_div,
    input logic                cfg_odd,
    input logic                mclk_o,
    input logic                bclk_o,
    input logic                bclk_tick_o,
    input logic                cfg_err_o
);
    logic req_bad;
    assign req_bad = ((cfg_div == AC_DIV_W'(1)) && cfg_odd) || (int'(cfg_div) > DIV_MAX);

    AST_TICK_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
        bclk_tick_o |-> bclk_o);                                        // R4

    AST_RISE_HAS_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(bclk_o) |-> bclk_tick_o);                                 // R4

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cfg_err_o && $past(cfg_err_o)) |-> (!bclk_o && !mclk_o && !bclk_tick_o)); // R5

    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cfg_err_o && req_bad) |=> cfg_err_o);                          // R5

    AST_ERR_RECOVERS: assert property (@(posedge clk) disable iff (rst)
        (cfg_err_o && !req_bad) |=> !cfg_err_o);                        // R6
endmodule

bind audclk_prescaler audclk_prescaler_chk #(.DIV_MAX(DIV_MAX)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_div     (cfg_div),
    .cfg_odd     (cfg_odd),
    .mclk_o      (mclk_o),
    .bclk_o      (bclk_o),
    .bclk_tick_o (bclk_tick_o),
    .cfg_err_o   (cfg_err_o)
);

// File: tb/tb_audclk_prescaler.sv
`timescale 1ns/1ps
module tb_audclk_prescaler;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_div = 8'd0;
    logic       cfg_odd = 1'b0;
    logic       cfg_mclk_en = 1'b0;
    logic       cfg_master = 1'b0;
    logic       cfg_pcm = 1'b0;
    logic       cfg_wide = 1'b0;
    logic       mclk_o, bclk_o, bclk_tick_o, cfg_err_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    audclk_prescaler dut (
        .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_odd(cfg_odd),
        .cfg_mclk_en(cfg_mclk_en), .cfg_master(cfg_master), .cfg_pcm(cfg_pcm),
        .cfg_wide(cfg_wide), .mclk_o(mclk_o), .bclk_o(bclk_o),
        .bclk_tick_o(bclk_tick_o), .cfg_err_o(cfg_err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int d, input bit o, input bit me, input bit ms,
                           input bit p, input bit w);
        @(negedge clk);
        cfg_div = 8'(d); cfg_odd = o; cfg_mclk_en = me;
        cfg_master = ms; cfg_pcm = p; cfg_wide = w;
    endtask

    task automatic wait_tick(output bit ok);
        ok = 1'b0;
        for (int n = 0; n < 5000; n++) begin
            @(negedge clk);
            if (bclk_tick_o) begin ok = 1'b1; break; end
        end
    endtask

    // One bit clock period: from a strobe up to the next one.
    task automatic measure(output int per, output int hi, output int mhi,
                           output bit rise_ok, output bit ok);
        bit prev_lo;
        per = 0; hi = 0; mhi = 0; rise_ok = 1'b1;
        wait_tick(ok);
        if (!ok) return;
        per = 1; hi = int'(bclk_o); mhi = int'(mclk_o);
        if (!bclk_o) rise_ok = 1'b0;
        for (int n = 0; n < 5000; n++) begin
            prev_lo = !bclk_o;
            @(negedge clk);
            if (bclk_tick_o) return;
            if (prev_lo && bclk_o) rise_ok = 1'b0;
            per++; hi += int'(bclk_o); mhi += int'(mclk_o);
        end
        ok = 1'b0;
    endtask

    task automatic settled(output int per, output int hi, output int mhi,
                           output bit rise_ok, output bit ok);
        for (int k = 0; k < 3; k++) measure(per, hi, mhi, rise_ok, ok);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!bclk_o && !mclk_o && !bclk_tick_o && !cfg_err_o, "R10 reset outputs",
            int'({bclk_o, mclk_o, bclk_tick_o, cfg_err_o}), 0);
    endtask

    task automatic t_direct(input int d, input bit o);
        int per, hi, mhi, r; bit rok, ok;
        r = 2 * d + int'(o);
        set_cfg(d, o, 1'b0, 1'b1, 1'b0, 1'b0);
        settled(per, hi, mhi, rok, ok);
        chk(ok && per == r, "R1 direct period", per, r);
        chk(ok && hi == (r + 1) / 2, "R3 high time", hi, (r + 1) / 2);
        chk(ok && rok, "R4 strobe on rising edge", int'(rok), 1);
        chk(mhi == 0, "R8 mclk idle when disabled", mhi, 0);
    endtask

    task automatic t_bypass(input bit o);
        int ticks = 0, highs = 0;
        set_cfg(0, o, 1'b0, 1'b1, 1'b0, 1'b0);
        repeat (300) @(negedge clk);
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            ticks += int'(bclk_tick_o); highs += int'(bclk_o);
        end
        chk(ticks == 20, "R2 bypass strobe each cycle", ticks, 20);
        chk(highs == 20, "R2 bypass level high", highs, 20);
    endtask

    task automatic t_illegal(input int d, input bit o);
        int act = 0;
        set_cfg(d, o, 1'b1, 1'b1, 1'b0, 1'b0);
        repeat (600) @(negedge clk);
        chk(cfg_err_o, "R5 error flag", int'(cfg_err_o), 1);
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            act += int'(bclk_o) + int'(mclk_o) + int'(bclk_tick_o);
        end
        chk(act == 0, "R5 outputs idle", act, 0);
    endtask

    task automatic t_recover();
        int per, hi, mhi; bit rok, ok;
        set_cfg(3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        chk(!cfg_err_o, "R6 error clears", int'(cfg_err_o), 0);
        measure(per, hi, mhi, rok, ok);
        chk(ok && per == 6 && hi == 3, "R6 restart full period", per * 100 + hi, 603);
    endtask

    task automatic t_mclk(input int d, input bit o, input bit p, input bit w);
        int per, hi, mhi, r, nf; bit rok, ok;
        r  = (d == 0) ? 1 : 2 * d + int'(o);
        nf = w ? 4 : 8;
        set_cfg(d, o, 1'b1, 1'b1, p, w);
        settled(per, hi, mhi, rok, ok);
        chk(ok && per == r * nf, "R7 bclk period", per, r * nf);
        chk(ok && hi == r * nf / 2, "R7 bclk high half", hi, r * nf / 2);
        chk(ok && mhi == nf * ((r + 1) / 2), "R7 mclk duty", mhi, nf * ((r + 1) / 2));
    endtask

    task automatic t_slave_mclk();
        int per, hi, mhi; bit rok, ok;
        set_cfg(4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        settled(per, hi, mhi, rok, ok);
        chk(ok && mhi == 0, "R8 mclk off in slave mode", mhi, 0);
        chk(ok && per == 9, "R8 direct bclk in slave mode", per, 9);
    endtask

    task automatic t_boundary();
        int per, hi, mhi; bit rok, ok;
        set_cfg(5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        settled(per, hi, mhi, rok, ok);
        wait_tick(ok);
        cfg_div = 8'd2;
        per = 1; hi = int'(bclk_o);
        for (int n = 0; n < 100; n++) begin
            @(negedge clk);
            if (bclk_tick_o) break;
            per++; hi += int'(bclk_o);
        end
        chk(per == 10 && hi == 5, "R9 running period kept", per * 100 + hi, 1005);
        per = 1;
        for (int n = 0; n < 100; n++) begin
            @(negedge clk);
            if (bclk_tick_o) break;
            per++;
        end
        chk(per == 4, "R9 new ratio next period", per, 4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk); rst = 1'b0;
        t_direct(2, 1'b0);
        t_direct(3, 1'b1);
        t_direct(1, 1'b0);
        t_direct(127, 1'b1);
        t_bypass(1'b0);
        t_bypass(1'b1);
        t_illegal(1, 1'b1);
        t_recover();
        t_illegal(128, 1'b0);
        t_recover();
        t_mclk(3, 1'b1, 1'b0, 1'b0);
        t_mclk(2, 1'b0, 1'b0, 1'b1);
        t_mclk(1, 1'b0, 1'b1, 1'b0);
        t_mclk(0, 1'b0, 1'b1, 1'b1);
        t_slave_mclk();
        t_boundary();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule